// File: doc/BRIEF.md
# Periodic Interrupt and Service Jitter Monitor

This block produces a periodic control-task interrupt whose timing comes only from the fabric clock. It also measures how punctually the processor answers that interrupt. The interrupt is raised once every `period` clock cycles and stays raised until the processor acknowledges it. If a new period boundary arrives while the interrupt is still pending, a sticky overrun flag records that a deadline was missed.

Each time the software control task runs, it strobes `task_evt`. The block stamps that strobe with a free-running tick counter that advances once per clock, so each tick is 25 ns at a 40 MHz clock. It takes the difference from the previous stamp. Over a capture run of a configured number of events, it keeps the latest interval and the smallest and largest intervals. A start pulse begins a new run and restarts the period timer. The `done` flag closes the run once the configured number of events has been counted. A run length of zero selects the default of 650 events.

Top module: `jitter_irq_monitor`

## Requirements
- R1: The tick counter advances by one on every clock edge. Intervals are the modulo-2^32 difference of stamps, so they stay correct across counter wraparound and equal the number of clock edges between the two strobes.
- R2: With a nonzero `period` P, `irq` rises after the P-th clock edge that follows the edge registering `start`, and a new period boundary follows every P edges. With `period` zero, no interrupt is raised.
- R3: Once high, `irq` stays high until `irq_ack` is seen at a clock edge. At that edge it clears, unless a period boundary falls on the same edge.
- R4: A period boundary that arrives while `irq` is pending and not acknowledged sets `irq_overrun`. The flag stays set until the next `start`.
- R5: `start` clears `evt_count`, `last_ival`, `max_ival`, `done`, `irq` and `irq_overrun`, and sets `min_ival` to all ones. A `task_evt` in the same cycle as `start` is not counted.
- R6: The first event of a run only records the reference stamp. `evt_count` becomes 1, while `last_ival`, `min_ival` and `max_ival` are left unchanged.
- R7: Each later event sets `last_ival` to its interval and updates `min_ival` and `max_ival`. These outputs are visible after the registering edge.
- R8: `done` rises when `evt_count` reaches the run length, where a `run_len` of zero means 650. After that, events change no output until the next `start`.
- R9: Before the first `start` after reset, events are ignored and `evt_count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new capture run and restart the period timer |
| period | input | 32 | Interrupt period in clock cycles; zero disables the interrupt |
| run_len | input | 16 | Events per run; zero selects 650 |
| irq_ack | input | 1 | Acknowledge from the processor |
| task_evt | input | 1 | Strobe from the control task, one per execution |
| irq | output | 1 | Pending periodic interrupt |
| irq_overrun | output | 1 | Sticky flag: a period passed while the interrupt was pending |
| last_ival | output | 32 | Most recent interval in ticks |
| min_ival | output | 32 | Smallest interval of the run |
| max_ival | output | 32 | Largest interval of the run |
| evt_count | output | 16 | Events counted in the current run |
| done | output | 1 | Run complete |

## Verification
Every result is registered once. Interval, minimum, maximum, count and done therefore change on the edge that samples the strobe. The interrupt rises on the P-th edge after the start edge, and an acknowledge clears it on the edge that samples it. The bench drives and samples on falling edges. It counts falling edges from the start pulse, so each check sits exactly one edge after the stimulus that should have caused it, or one edge before a boundary for the "not yet" cases. Gaps and periods are swept over small ranges, and the expected values are simply the gap lengths and period multiples.

// File: rtl/jm_pkg.sv
package jm_pkg;
    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;
endpackage

// File: rtl/jm_tick_counter.sv
module jm_tick_counter #(
    parameter int          TICK_W    = 32,
    parameter logic [31:0] TICK_INIT = 32'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TICK_W-1:0] tick_o
);
    logic [TICK_W-1:0] tick_d, tick_q;

    always_comb begin
        tick_d = tick_q + {{(TICK_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= TICK_INIT[TICK_W-1:0];
        else        tick_q <= tick_d;
    end

    assign tick_o = tick_q;
endmodule

// File: rtl/jm_period_timer.sv
module jm_period_timer #(
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                ack_i,
    output logic                irq_o,
    output logic                overrun_o
);
    typedef struct packed {
        logic                active;
        logic [PERIOD_W-1:0] cnt;
        logic                irq;
        logic                ovr;
    } timer_t;

    localparam logic [PERIOD_W-1:0] ONE = {{(PERIOD_W-1){1'b0}}, 1'b1};

    timer_t st_d, st_q;
    logic   enabled, boundary;

    always_comb begin
        st_d     = st_q;
        enabled  = st_q.active && (period_i != '0);
        boundary = enabled && (st_q.cnt >= period_i - ONE);
        if (enabled) st_d.cnt = boundary ? '0 : st_q.cnt + ONE;
        if (boundary) begin
            st_d.irq = 1'b1;
            if (st_q.irq && !ack_i) st_d.ovr = 1'b1;
        end else if (ack_i) begin
            st_d.irq = 1'b0;
        end
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.irq    = 1'b0;
            st_d.ovr    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o     = st_q.irq;
    assign overrun_o = st_q.ovr;
endmodule

// File: rtl/jm_interval_stats.sv
module jm_interval_stats
    import jm_pkg::*;
#(
    parameter int TICK_W      = 32,
    parameter int RUN_W       = 16,
    parameter int DEF_RUN_LEN = 650
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RUN_W-1:0]  run_len_i,
    input  logic              evt_i,
    input  logic [TICK_W-1:0] stamp_i,
    output logic [TICK_W-1:0] last_o,
    output logic [TICK_W-1:0] min_o,
    output logic [TICK_W-1:0] max_o,
    output logic [RUN_W-1:0]  count_o,
    output logic              done_o
);
    localparam logic [RUN_W-1:0] DEF_LEN = RUN_W'(DEF_RUN_LEN);
    localparam logic [RUN_W-1:0] ONE     = {{(RUN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        run_state_e        state;
        logic [TICK_W-1:0] ref_stamp;
        logic [TICK_W-1:0] last;
        logic [TICK_W-1:0] min;
        logic [TICK_W-1:0] max;
        logic [RUN_W-1:0]  count;
        logic              done;
    } stats_t;

    stats_t            st_d, st_q;
    logic [RUN_W-1:0]  eff_len;
    logic [TICK_W-1:0] ival;
    logic              take;

    always_comb begin
        st_d    = st_q;
        eff_len = (run_len_i == '0) ? DEF_LEN : run_len_i;
        ival    = stamp_i - st_q.ref_stamp;
        take    = evt_i && (st_q.state == RUN_ACTIVE) && !st_q.done;
        if (start_i) begin
            st_d.state = RUN_ACTIVE;
            st_d.last  = '0;
            st_d.min   = '1;
            st_d.max   = '0;
            st_d.count = '0;
            st_d.done  = 1'b0;
        end else if (take) begin
            st_d.ref_stamp = stamp_i;
            if (st_q.count != '0) begin
                st_d.last = ival;
                if (ival < st_q.min) st_d.min = ival;
                if (ival > st_q.max) st_d.max = ival;
            end
            st_d.count = st_q.count + ONE;
            if (st_q.count + ONE == eff_len) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= RUN_IDLE;
            st_q.min   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o  = st_q.last;
    assign min_o   = st_q.min;
    assign max_o   = st_q.max;
    assign count_o = st_q.count;
    assign done_o  = st_q.done;
endmodule

// File: rtl/jitter_irq_monitor.sv
module jitter_irq_monitor #(
    parameter int          TICK_W      = 32,
    parameter int          PERIOD_W    = 32,
    parameter int          RUN_W       = 16,
    parameter int          DEF_RUN_LEN = 650,
    parameter logic [31:0] TICK_INIT   = 32'd0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PERIOD_W-1:0] period,
    input  logic [RUN_W-1:0]    run_len,
    input  logic                irq_ack,
    input  logic                task_evt,
    output logic                irq,
    output logic                irq_overrun,
    output logic [TICK_W-1:0]   last_ival,
    output logic [TICK_W-1:0]   min_ival,
    output logic [TICK_W-1:0]   max_ival,
    output logic [RUN_W-1:0]    evt_count,
    output logic                done
);
    logic [TICK_W-1:0] stamp;

    jm_tick_counter #(.TICK_W(TICK_W), .TICK_INIT(TICK_INIT)) u_ticks (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (stamp)
    );

    jm_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .period_i  (period),
        .ack_i     (irq_ack),
        .irq_o     (irq),
        .overrun_o (irq_overrun)
    );

    jm_interval_stats #(
        .TICK_W(TICK_W), .RUN_W(RUN_W), .DEF_RUN_LEN(DEF_RUN_LEN)
    ) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .run_len_i (run_len),
        .evt_i     (task_evt),
        .stamp_i   (stamp),
        .last_o    (last_ival),
        .min_o     (min_ival),
        .max_o     (max_ival),
        .count_o   (evt_count),
        .done_o    (done)
    );
endmodule

// File: rtl/jitter_irq_monitor_chk.sv
module jitter_irq_monitor_chk #(
    parameter int TICK_W = 32,
    parameter int RUN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              irq_ack,
    input logic              irq,
    input logic              irq_overrun,
    input logic [TICK_W-1:0] last_ival,
    input logic [TICK_W-1:0] min_ival,
    input logic [TICK_W-1:0] max_ival,
    input logic [RUN_W-1:0]  evt_count,
    input logic              done
);
    a_r3_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && !start) |=> irq);

    a_r4_overrun_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_overrun) |-> $past(irq));

    a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (evt_count == '0 && !done && !irq && !irq_overrun &&
                   min_ival == {TICK_W{1'b1}} && max_ival == '0 && last_ival == '0));

    a_r7_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_count >= RUN_W'(2)) |-> (min_ival <= max_ival));

    a_r8_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(evt_count) && $stable(last_ival) &&
                              $stable(min_ival) && $stable(max_ival) && done));
endmodule

bind jitter_irq_monitor jitter_irq_monitor_chk #(.TICK_W(TICK_W), .RUN_W(RUN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .irq_ack     (irq_ack),
    .irq         (irq),
    .irq_overrun (irq_overrun),
    .last_ival   (last_ival),
    .min_ival    (min_ival),
    .max_ival    (max_ival),
    .evt_count   (evt_count),
    .done        (done)
);

// File: tb/jitter_irq_monitor_bench.sv
`timescale 1ns/1ps
module jitter_irq_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n, start, irq_ack, task_evt;
    logic [31:0] period;
    logic [15:0] run_len;
    logic        irq, irq_overrun, done;
    logic [31:0] last_ival, min_ival, max_ival;
    logic [15:0] evt_count;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    jitter_irq_monitor #(.TICK_INIT(32'hFFFF_FFF0)) u_jitter_irq_monitor (
        .clk(clk), .rst_n(rst_n), .start(start), .period(period),
        .run_len(run_len), .irq_ack(irq_ack), .task_evt(task_evt),
        .irq(irq), .irq_overrun(irq_overrun), .last_ival(last_ival),
        .min_ival(min_ival), .max_ival(max_ival), .evt_count(evt_count),
        .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic evt_pulse();
        task_evt = 1'b1;
        @(negedge clk);
        task_evt = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int gaps [4] = '{3, 7, 2, 4};
        logic [31:0] emin, emax;
        rst_n = 1'b0; start = 1'b0; irq_ack = 1'b0; task_evt = 1'b0;
        period = 32'd0; run_len = 16'd0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset irq", {31'd0, irq}, 32'd0);
        chk("R5 reset done", {31'd0, done}, 32'd0);
        chk("R5 reset count", {16'd0, evt_count}, 32'd0);

        evt_pulse();
        chk("R9 event before start", {16'd0, evt_count}, 32'd0);

        // first run, spans tick counter wraparound (R1)
        run_len = 16'd5;
        do_start();
        chk("R5 min after start", min_ival, 32'hFFFF_FFFF);
        chk("R5 max after start", max_ival, 32'd0);
        evt_pulse();
        chk("R6 count after first", {16'd0, evt_count}, 32'd1);
        chk("R6 last after first", last_ival, 32'd0);
        chk("R6 min after first", min_ival, 32'hFFFF_FFFF);
        emin = 32'hFFFF_FFFF;
        emax = 32'd0;
        for (int i = 0; i < 4; i++) begin
            idle(gaps[i] - 1);
            evt_pulse();
            if (gaps[i] < emin) emin = gaps[i];
            if (gaps[i] > emax) emax = gaps[i];
            chk("R1 R7 last interval", last_ival, gaps[i]);
            chk("R7 min", min_ival, emin);
            chk("R7 max", max_ival, emax);
            chk("R8 count", {16'd0, evt_count}, i + 2);
            chk("R8 done", {31'd0, done}, (i == 3) ? 32'd1 : 32'd0);
        end
        idle(2);
        evt_pulse();
        chk("R8 ignored count", {16'd0, evt_count}, 32'd5);
        chk("R8 ignored last", last_ival, 32'd4);
        chk("R8 ignored min", min_ival, 32'd2);
        chk("R8 ignored max", max_ival, 32'd7);

        // gap sweep
        for (int g = 1; g <= 12; g++) begin
            run_len = 16'd2;
            do_start();
            evt_pulse();
            idle(g - 1);
            evt_pulse();
            chk("R7 sweep last", last_ival, g);
            chk("R7 sweep min", min_ival, g);
            chk("R7 sweep max", max_ival, g);
            chk("R8 sweep done", {31'd0, done}, 32'd1);
        end

        // default run length
        run_len = 16'd0;
        do_start();
        repeat (649) evt_pulse();
        chk("R8 default not yet done", {31'd0, done}, 32'd0);
        chk("R8 default count", {16'd0, evt_count}, 32'd649);
        evt_pulse();
        chk("R8 default done", {31'd0, done}, 32'd1);
        chk("R8 default count full", {16'd0, evt_count}, 32'd650);
        chk("R7 default max", max_ival, 32'd1);

        // start wins over same-cycle event
        run_len = 16'd3;
        start = 1'b1; task_evt = 1'b1;
        @(negedge clk);
        start = 1'b0; task_evt = 1'b0;
        chk("R5 start beats event", {16'd0, evt_count}, 32'd0);

        // interrupt period sweep
        for (int p = 2; p <= 8; p++) begin
            period = p;
            do_start();
            idle(p - 1);
            chk("R2 irq not yet", {31'd0, irq}, 32'd0);
            idle(1);
            chk("R2 irq rises", {31'd0, irq}, 32'd1);
            irq_ack = 1'b1;
            @(negedge clk);
            irq_ack = 1'b0;
            chk("R3 ack clears", {31'd0, irq}, 32'd0);
            idle(p - 2);
            chk("R2 second not yet", {31'd0, irq}, 32'd0);
            idle(1);
            chk("R2 second rise", {31'd0, irq}, 32'd1);
            idle(p - 1);
            chk("R3 irq held", {31'd0, irq}, 32'd1);
            chk("R4 no overrun yet", {31'd0, irq_overrun}, 32'd0);
            idle(1);
            chk("R4 overrun set", {31'd0, irq_overrun}, 32'd1);
            idle(p);
            chk("R4 overrun sticky", {31'd0, irq_overrun}, 32'd1);
            do_start();
            chk("R5 start clears overrun", {31'd0, irq_overrun}, 32'd0);
            chk("R5 start clears irq", {31'd0, irq}, 32'd0);
        end

        period = 32'd0;
        do_start();
        idle(20);
        chk("R2 period zero no irq", {31'd0, irq}, 32'd0);

        summary();
        $finish;
    end
endmodule